// File: doc/BRIEF.md
# Complementary PWM Timer with Dead-Time Insertion

This block is a 16-bit timer for driving three half-bridges. An integer prescaler sets the tick rate. An auto-reload counter counts up, counts down, or counts up then down (centre-aligned). Three compare channels each make a PWM reference. Each reference drives a pair of outputs, a main one and its complement. After one output of a pair turns off, the other waits a programmed number of clocks before it turns on. A fourth compare channel has no pins and only raises a match flag.

Compare, auto-reload and prescaler values are taken straight from the configuration inputs while the counter is stopped. While it runs, they are taken only at an update event, so a period that has started is never disturbed. A break input forces every output to its programmed safe level in the same cycle and clears the main-output enable. Outputs stay safe until the enable is set again. Single-pulse operation stops the counter at its first update event.

Top module: `pwm_dt_timer`

## Requirements
- R1: The counter advances once every `cfg_psc`+1 clocks while running (`cnt_en` high and not stopped by single-pulse operation).
- R2: `cfg_mode`=0 (up): the counter runs 0..`cfg_arr`, returns to 0 and signals an update at that return, so one period is (`cfg_psc`+1)*(`cfg_arr`+1) clocks. `cnt_val` never exceeds the active reload value, and reads 0 out of reset.
- R3: `cfg_mode`=1 (down): the counter is preset to `cfg_arr` when stopped, runs down to 0, reloads and signals an update at the reload. The period is (`cfg_psc`+1)*(`cfg_arr`+1) clocks.
- R4: `cfg_mode`=2 (centre): the counter runs 0 up to `cfg_arr` and back down to 0 (`cfg_arr` >= 1). The update is signalled only when it leaves 0 going up after a down sweep. The period is 2*`cfg_arr`*(`cfg_psc`+1) clocks.
- R5: Reload, compare and prescale values follow the inputs while the counter is stopped. While it runs, they change only at an update event, so the period in progress keeps its old length.
- R6: Compare value j is `cfg_cmp[16*j+15:16*j]`. Pin channel i's reference is high while the counter is below its compare value. `out_hi[i]` follows the reference and `out_lo[i]` follows its inverse. The output turning off changes one clock after the counter changes. The output turning on changes `cfg_dtime` clocks after that. The two outputs of a pair are never high together.
- R7: Out of reset, and whenever main-output enable is clear, `out_hi`/`out_lo` equal `cfg_safe_hi`/`cfg_safe_lo`. A one-cycle `moe_set` pulse sets the enable.
- R8: While `brk_in` is high, the outputs equal the safe levels in that same cycle and the enable is cleared. `moe_set` has no effect while `brk_in` is high. The outputs stay safe after break is released until a new `moe_set`.
- R9: With `cfg_opm` high, the counter stops after its first update event and holds. It restarts only after `cnt_en` goes low and then high.
- R10: `flag_upd` pulses in the first cycle the counter shows its post-update value. `flag_cmp[j]` (j=0..3; j=3 is the pinless channel) pulses one cycle after the counter takes value equal to compare j. `flag_brk` is high the cycle after each cycle with `brk_in` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Run enable for the counter |
| cfg_mode | input | 2 | 0 up, 1 down, 2 centre-aligned |
| cfg_opm | input | 1 | Single-pulse operation |
| cfg_psc | input | 16 | Prescale divide minus one |
| cfg_arr | input | 16 | Auto-reload value |
| cfg_cmp | input | 64 | Four 16-bit compare values, channel j at bits 16j+15:16j |
| cfg_dtime | input | 8 | Dead time in clocks |
| cfg_safe_hi | input | 3 | Safe levels of main outputs |
| cfg_safe_lo | input | 3 | Safe levels of complementary outputs |
| moe_set | input | 1 | Sets main-output enable |
| brk_in | input | 1 | Break request |
| out_hi | output | 3 | Main PWM outputs |
| out_lo | output | 3 | Complementary PWM outputs |
| cnt_val | output | 16 | Current counter value |
| flag_upd | output | 1 | Update event pulse |
| flag_cmp | output | 4 | Compare match pulses |
| flag_brk | output | 1 | Break seen |

## Verification
Break forcing is due in the cycle `brk_in` rises, so the bench samples 1 ns after driving it. `flag_brk` is due one edge later. `flag_upd` is due with the wrapped counter value, and `flag_cmp` one edge after the match value appears. Output edges lag the counter by one clock, plus `cfg_dtime` for the edge that turns on. Rather than chasing individual edges, the checks align on a `flag_upd` sample and skip one settling period. They then integrate over exactly one period the high time of each output, the gap time, the overlap and the flag pulses. They compare these totals with closed-form values from the prescale, reload, compare and dead-time settings.

// File: rtl/pwmt_pkg.sv
// Shared types for the complementary PWM timer.
package pwmt_pkg;
    typedef enum logic [1:0] {
        CNT_UP     = 2'd0,
        CNT_DOWN   = 2'd1,
        CNT_CENTRE = 2'd2
    } cnt_mode_e;
endpackage

// File: rtl/pwmt_prescaler.sv
// Integer prescaler: emits one tick every (div+1) clocks while run is high.
// Assumes div is stable between ticks (it is a preloaded shadow value).
module pwmt_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PSC_W-1:0] div,
    output logic             tick
);
    logic [PSC_W-1:0] pcnt;

    assign tick = run && (pcnt >= div);

    // Divider count: restarts on each tick and whenever the timer is stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pcnt <= '0;
        else if (!run || tick)
            pcnt <= '0;
        else
            pcnt <= pcnt + PSC_W'(1);
    end
endmodule

// File: rtl/pwmt_counter.sv
// Auto-reload counter with up, down and centre-aligned sequences.
// top is the active reload value; reload is the value the shadow will hold
// after the current edge (used for presets and down-count reloads).
// Assumes top >= 1 in centre mode.
module pwmt_counter
    import pwmt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  cnt_mode_e        mode,
    input  logic [CNT_W-1:0] top,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output logic             upd,
    output logic             moved
);
    logic dir_dn;

    // Update condition: the tick that wraps the counter for the chosen mode.
    always_comb begin
        case (mode)
            CNT_DOWN:   upd = tick && (cnt == '0);
            CNT_CENTRE: upd = tick && dir_dn && (cnt == '0);
            default:    upd = tick && (cnt >= top);
        endcase
    end

    // Count sequence, direction and the "advanced last edge" marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            dir_dn <= 1'b0;
            moved  <= 1'b0;
        end else begin
            moved <= tick;
            if (!run) begin
                cnt    <= (mode == CNT_DOWN) ? reload : '0;
                dir_dn <= 1'b0;
            end else if (tick) begin
                case (mode)
                    CNT_DOWN:
                        cnt <= (cnt == '0) ? reload : cnt - CNT_W'(1);
                    CNT_CENTRE: begin
                        if (!dir_dn) begin
                            if (cnt >= top) begin
                                dir_dn <= 1'b1;
                                cnt    <= top - CNT_W'(1);
                            end else begin
                                cnt <= cnt + CNT_W'(1);
                            end
                        end else if (cnt == '0) begin
                            dir_dn <= 1'b0;
                            cnt    <= CNT_W'(1);
                        end else begin
                            cnt <= cnt - CNT_W'(1);
                        end
                    end
                    default:
                        cnt <= (cnt >= top) ? '0 : cnt + CNT_W'(1);
                endcase
            end
        end
    end

    // R2: the count stays within the active reload value.
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= top);
endmodule

// File: rtl/pwmt_deadtime.sv
// Dead-time generator for one complementary pair. The output being switched
// off drops one clock after the reference changes; the other rises after a
// further dt clocks. A reference change restarts the wait.
module pwmt_deadtime #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ref_i,
    input  logic [DT_W-1:0] dt,
    output logic            hi,
    output logic            lo
);
    logic            ref_q;
    logic [DT_W-1:0] wait_cnt;
    logic [DT_W-1:0] eff;

    assign eff = (ref_i != ref_q) ? '0 : wait_cnt;

    // Pair state: turn the losing side off at once, the winning side on later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q    <= 1'b0;
            hi       <= 1'b0;
            lo       <= 1'b0;
            wait_cnt <= '0;
        end else begin
            ref_q <= ref_i;
            if (ref_i) begin
                lo <= 1'b0;
                if (hi)
                    wait_cnt <= '0;
                else if (eff >= dt) begin
                    hi       <= 1'b1;
                    wait_cnt <= '0;
                end else
                    wait_cnt <= eff + DT_W'(1);
            end else begin
                hi <= 1'b0;
                if (lo)
                    wait_cnt <= '0;
                else if (eff >= dt) begin
                    lo       <= 1'b1;
                    wait_cnt <= '0;
                end else
                    wait_cnt <= eff + DT_W'(1);
            end
        end
    end

    // R6: the two sides of a pair are never on together.
    p_pair_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi && lo));
endmodule

// File: rtl/pwm_dt_timer.sv
// Complementary PWM timer: prescaler, reload counter, four preloaded compare
// channels (three with pin pairs and dead time, one flag-only), break and
// main-output enable, single-pulse stop and event flags.
// Assumes configuration inputs are static except where preloading applies.
module pwm_dt_timer
    import pwmt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16,
    parameter int DT_W  = 8,
    parameter int N_PIN = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cnt_en,
    input  logic [1:0]                 cfg_mode,
    input  logic                       cfg_opm,
    input  logic [PSC_W-1:0]           cfg_psc,
    input  logic [CNT_W-1:0]           cfg_arr,
    input  logic [(N_PIN+1)*CNT_W-1:0] cfg_cmp,
    input  logic [DT_W-1:0]            cfg_dtime,
    input  logic [N_PIN-1:0]           cfg_safe_hi,
    input  logic [N_PIN-1:0]           cfg_safe_lo,
    input  logic                       moe_set,
    input  logic                       brk_in,
    output logic [N_PIN-1:0]           out_hi,
    output logic [N_PIN-1:0]           out_lo,
    output logic [CNT_W-1:0]           cnt_val,
    output logic                       flag_upd,
    output logic [N_PIN:0]             flag_cmp,
    output logic                       flag_brk
);
    localparam int N_CMP = N_PIN + 1;

    logic                   halted, active, tick, upd, moved, moe, drive_en;
    logic [CNT_W-1:0]       cnt, arr_sh, arr_nx;
    logic [PSC_W-1:0]       psc_sh;
    logic [N_CMP*CNT_W-1:0] cmp_sh;
    logic [N_PIN-1:0]       dt_hi, dt_lo;
    cnt_mode_e              mode;

    assign mode     = cnt_mode_e'(cfg_mode);
    assign active   = cnt_en && !halted;
    assign arr_nx   = (!active || upd) ? cfg_arr : arr_sh;
    assign cnt_val  = cnt;
    assign drive_en = moe && !brk_in;

    // Shadow registers: transparent while stopped, loaded at update events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr_sh <= '0;
            psc_sh <= '0;
            cmp_sh <= '0;
        end else if (!active || upd) begin
            arr_sh <= cfg_arr;
            psc_sh <= cfg_psc;
            cmp_sh <= cfg_cmp;
        end
    end

    // Single-pulse stop: latch at the update, clear when the enable drops.
    always_ff @(posedge clk) begin
        if (!rst_n || !cnt_en)
            halted <= 1'b0;
        else if (upd && cfg_opm)
            halted <= 1'b1;
    end

    // Main-output enable: break clears it and wins over a set request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            moe <= 1'b0;
        else if (brk_in)
            moe <= 1'b0;
        else if (moe_set)
            moe <= 1'b1;
    end

    // Event flags for update and break.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_upd <= 1'b0;
            flag_brk <= 1'b0;
        end else begin
            flag_upd <= upd;
            flag_brk <= brk_in;
        end
    end

    pwmt_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .run(active), .div(psc_sh), .tick(tick)
    );

    pwmt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(active), .tick(tick), .mode(mode),
        .top(arr_sh), .reload(arr_nx), .cnt(cnt), .upd(upd), .moved(moved)
    );

    for (genvar j = 0; j < N_CMP; j++) begin : g_cmp
        logic [CNT_W-1:0] cval;
        assign cval = cmp_sh[j*CNT_W +: CNT_W];

        // Match flag: the counter has just advanced onto this compare value.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_cmp[j] <= 1'b0;
            else
                flag_cmp[j] <= moved && (cnt == cval);
        end

        if (j < N_PIN) begin : g_pin
            logic pwm_ref;
            assign pwm_ref = cnt < cval;

            pwmt_deadtime #(.DT_W(DT_W)) u_dt (
                .clk(clk), .rst_n(rst_n), .ref_i(pwm_ref), .dt(cfg_dtime),
                .hi(dt_hi[j]), .lo(dt_lo[j])
            );
        end
    end

    // Output stage: pair values when enabled, safe levels otherwise.
    always_comb begin
        out_hi = drive_en ? dt_hi : cfg_safe_hi;
        out_lo = drive_en ? dt_lo : cfg_safe_lo;
    end

    // R5: shadows hold while running between update events.
    p_preload_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !upd) |=> ($stable(arr_sh) && $stable(cmp_sh)));
    // R9: a stopped single-pulse counter receives no ticks.
    p_opm_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !tick);
    // R8: break leaves the main-output enable clear.
    p_brk_moe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        brk_in |=> !moe);
    // R10: an update event is followed by the update flag.
    p_upd_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> flag_upd);
endmodule

// File: tb/pwm_dt_timer_test.sv
module pwm_dt_timer_test;
    localparam int NP = 3;

    logic        clk = 1'b0, rst_n = 1'b0, cnt_en = 1'b0, cfg_opm = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic [15:0] cfg_psc = '0, cfg_arr = '0;
    logic [63:0] cfg_cmp = '0;
    logic [7:0]  cfg_dtime = '0;
    logic [2:0]  cfg_safe_hi = 3'b000, cfg_safe_lo = 3'b111;
    logic        moe_set = 1'b0, brk_in = 1'b0;
    logic [2:0]  out_hi, out_lo;
    logic [15:0] cnt_val;
    logic        flag_upd, flag_brk;
    logic [3:0]  flag_cmp;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwm_dt_timer uut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cfg_mode(cfg_mode),
        .cfg_opm(cfg_opm), .cfg_psc(cfg_psc), .cfg_arr(cfg_arr),
        .cfg_cmp(cfg_cmp), .cfg_dtime(cfg_dtime), .cfg_safe_hi(cfg_safe_hi),
        .cfg_safe_lo(cfg_safe_lo), .moe_set(moe_set), .brk_in(brk_in),
        .out_hi(out_hi), .out_lo(out_lo), .cnt_val(cnt_val),
        .flag_upd(flag_upd), .flag_cmp(flag_cmp), .flag_brk(flag_brk)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int period_of(int mode, int psc, int arr);
        return (mode == 2) ? 2 * arr * (psc + 1) : (arr + 1) * (psc + 1);
    endfunction

    function automatic int ref_high(int mode, int psc, int c);
        return (mode == 2) ? (2 * c - 1) * (psc + 1) : c * (psc + 1);
    endfunction

    function automatic int match_count(int mode, int arr, int c);
        return (mode == 2 && c < arr) ? 2 : 1;
    endfunction

    function automatic string mode_req(int mode);
        return (mode == 0) ? "R2" : (mode == 1) ? "R3" : "R4";
    endfunction

    task automatic pulse_moe();
        @(negedge clk); moe_set = 1'b1;
        @(negedge clk); moe_set = 1'b0;
    endtask

    task automatic setup(int mode, int psc, int arr, int c0, int c1, int c2, int c3, int dt);
        @(negedge clk); cnt_en = 1'b0;
        repeat (2) @(negedge clk);
        cfg_mode = 2'(mode); cfg_psc = 16'(psc); cfg_arr = 16'(arr);
        cfg_cmp = {16'(c3), 16'(c2), 16'(c1), 16'(c0)}; cfg_dtime = 8'(dt);
        repeat (2) @(negedge clk);
        cnt_en = 1'b1;
    endtask

    // Waits (sampling at negedge) for a flag_upd sample; reports the cycles spent.
    task automatic wait_upd(output int n, output bit ok);
        ok = 1'b0; n = 0;
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk); n++;
            if (flag_upd) begin ok = 1'b1; break; end
        end
    endtask

    // Integrates one full period after settling and checks the totals.
    task automatic measure(int mode, int psc, int arr, int c0, int c1, int c2, int c3, int dt);
        int p, n, upds, bad_bound, hi_n[NP], lo_n[NP], gap_n[NP], ovl[NP], fl[4], cs[4];
        bit ok;
        string rq;
        cs = '{c0, c1, c2, c3};
        p = period_of(mode, psc, arr);
        rq = mode_req(mode);
        wait_upd(n, ok); wait_upd(n, ok);
        chk(ok, {rq, " sync"}, int'(ok), 1);
        upds = 0; bad_bound = 0;
        for (int i = 0; i < NP; i++) begin hi_n[i] = 0; lo_n[i] = 0; gap_n[i] = 0; ovl[i] = 0; end
        for (int j = 0; j < 4; j++) fl[j] = 0;
        for (int s = 1; s <= p; s++) begin
            @(negedge clk);
            if (flag_upd) upds += (s == p) ? 1 : 100;
            if (int'(cnt_val) > arr) bad_bound++;
            for (int i = 0; i < NP; i++) begin
                hi_n[i] += int'(out_hi[i]);
                lo_n[i] += int'(out_lo[i]);
                if (!out_hi[i] && !out_lo[i]) gap_n[i]++;
                if (out_hi[i] && out_lo[i]) ovl[i]++;
            end
            for (int j = 0; j < 4; j++) fl[j] += int'(flag_cmp[j]);
        end
        chk(upds == 1, {rq, " R1 period/update"}, upds, 1);
        chk(bad_bound == 0, "R2 count bound", bad_bound, 0);
        for (int i = 0; i < NP; i++) begin
            chk(hi_n[i] == ref_high(mode, psc, cs[i]) - dt, "R6 main high time",
                hi_n[i], ref_high(mode, psc, cs[i]) - dt);
            chk(lo_n[i] == p - ref_high(mode, psc, cs[i]) - dt, "R6 complement high time",
                lo_n[i], p - ref_high(mode, psc, cs[i]) - dt);
            chk(gap_n[i] == 2 * dt, "R6 dead gap", gap_n[i], 2 * dt);
            chk(ovl[i] == 0, "R6 overlap", ovl[i], 0);
        end
        for (int j = 0; j < 4; j++)
            chk(fl[j] == match_count(mode, arr, cs[j]), "R10 compare flags",
                fl[j], match_count(mode, arr, cs[j]));
    endtask

    initial begin
        int n, m, c[4], psc, arr, dt, mode, ups;
        bit ok, safe_ok;
        n = int'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_hi == 3'b000 && out_lo == 3'b111, "R7 reset safe", int'({out_hi, out_lo}), 7);
        chk(cnt_val == 0, "R2 reset count", int'(cnt_val), 0);
        chk(flag_upd == 0 && flag_cmp == 0 && flag_brk == 0, "R10 reset flags",
            int'({flag_upd, flag_cmp, flag_brk}), 0);

        // R7: running without the enable keeps safe levels.
        setup(0, 0, 9, 3, 5, 7, 4, 2);
        safe_ok = 1'b1;
        repeat (25) begin
            @(negedge clk);
            if (out_hi != 3'b000 || out_lo != 3'b111) safe_ok = 1'b0;
        end
        chk(safe_ok, "R7 safe without enable", int'(safe_ok), 1);
        pulse_moe();

        // Directed cases.
        measure(0, 0, 9, 3, 5, 7, 4, 2);
        setup(0, 2, 4, 1, 2, 4, 3, 0);   measure(0, 2, 4, 1, 2, 4, 3, 0);   // R1
        setup(1, 1, 7, 2, 4, 6, 7, 1);   measure(1, 1, 7, 2, 4, 6, 7, 1);   // R3
        setup(2, 0, 8, 1, 4, 8, 8, 0);   measure(2, 0, 8, 1, 4, 8, 8, 0);   // R4 ends
        setup(2, 1, 6, 2, 3, 5, 1, 2);   measure(2, 1, 6, 2, 3, 5, 1, 2);   // R4

        // Random cases with fixed seed.
        for (int t = 0; t < 8; t++) begin
            mode = int'($urandom_range(0, 2));
            psc  = int'($urandom_range(0, 2));
            arr  = int'($urandom_range(4, 16));
            dt   = int'($urandom_range(0, psc + 1));
            for (int j = 0; j < 4; j++) c[j] = int'($urandom_range(2, arr - 1));
            setup(mode, psc, arr, c[0], c[1], c[2], c[3], dt);
            measure(mode, psc, arr, c[0], c[1], c[2], c[3], dt);
        end

        // R5: reload change mid-run takes effect one period later.
        setup(0, 0, 9, 3, 5, 7, 4, 0);
        wait_upd(n, ok); wait_upd(n, ok);
        cfg_arr = 16'd14;
        wait_upd(n, ok);
        chk(n == 10, "R5 old period kept", n, 10);
        wait_upd(n, ok);
        chk(n == 15, "R5 new period", n, 15);

        // R9: single-pulse stop and restart.
        @(negedge clk); cnt_en = 1'b0; cfg_opm = 1'b1;
        setup(0, 0, 5, 1, 2, 3, 4, 0);
        ups = 0;
        repeat (30) begin @(negedge clk); ups += int'(flag_upd); end
        chk(ups == 1, "R9 one update", ups, 1);
        chk(cnt_val == 0, "R9 held count", int'(cnt_val), 0);
        @(negedge clk); cnt_en = 1'b0;
        @(negedge clk); cnt_en = 1'b1;
        ups = 0;
        repeat (30) begin @(negedge clk); ups += int'(flag_upd); end
        chk(ups == 1, "R9 restart", ups, 1);
        cfg_opm = 1'b0;

        // R8: break forces safe levels at once, blocks moe_set, sticks.
        setup(0, 0, 9, 3, 5, 7, 4, 1);
        repeat (20) @(negedge clk);
        cfg_safe_hi = 3'b101; cfg_safe_lo = 3'b010;
        brk_in = 1'b1; moe_set = 1'b1;
        #1;
        chk(out_hi == 3'b101 && out_lo == 3'b010, "R8 immediate safe",
            int'({out_hi, out_lo}), 6'b101010);
        @(negedge clk);
        chk(flag_brk == 1'b1, "R10 break flag", int'(flag_brk), 1);
        brk_in = 1'b0; moe_set = 1'b0;
        safe_ok = 1'b1;
        repeat (20) begin
            @(negedge clk);
            if (out_hi != 3'b101 || out_lo != 3'b010) safe_ok = 1'b0;
        end
        chk(safe_ok, "R8 stays safe, moe_set ignored", int'(safe_ok), 1);
        @(negedge clk);
        chk(flag_brk == 1'b0, "R10 break flag clears", int'(flag_brk), 0);
        pulse_moe();
        measure(0, 0, 9, 3, 5, 7, 4, 1);   // R7 enable restores PWM

        m = n;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule